// File: doc/BRIEF.md
# HDSL Loop Overhead Multiplexer with CRC6

This block builds the outgoing bit stream of one HDSL loop. It takes payload bits through a ready/valid handshake and interleaves them with overhead: a 14-bit sync placeholder at the head of each frame, 32 overhead bits split into equal groups, and, when requested, four stuffing bits at the tail. The 32 overhead bits are 19 indicator bits and 13 embedded operations channel (eoc) bits. The indicators are a CRC6 field, a far-end block error flag, a loss-of-signal flag, a bipolar-violation flag and ten general status bits.

The transceiver downstream paces the block with a one-cycle bit enable. Each enabled cycle produces one output bit one clock later. The sync field goes out as zeros with a strobe, so the transceiver can put its own sync word in place. Host-written values (eoc, status, stuffing content, stuffing request) and the line flags are all captured on the first bit of a frame.

A CRC6 is accumulated over the frame's protected bits: the indicator and eoc bits other than the CRC field, plus every payload bit. That remainder goes out in the next frame. A one-shot request inverts one CRC field, so loop error handling can be tested.

Top module: `hoh_mux`

## Requirements
- R1: With default parameters a frame without stuffing is 110 output bits: the 14-bit sync field, then four repetitions of (8 overhead bits followed by 16 payload bits). `tx_fstart` is high on exactly the first bit of each frame.
- R2: Sync field bits are output as 0, with `tx_sync` high on those 14 bits only.
- R3: `stuff_req` is sampled on the first bit of a frame. When it is 1, four bits are appended after the last payload block, taken from `zbits_i` (also sampled on the first bit), bit 0 first. The frame is then 114 bits long.
- R4: Overhead index k (0..31, in transmit order) carries: k=0..5 the CRC6, most significant bit first; k=6 far-end block error; k=7 loss of signal; k=8 bipolar violation; k=9..18 `status_i[k-9]`; k=19..31 `eoc_i[k-19]`. Group g holds indices 8g..8g+7.
- R5: `los_i`, `bpv_i`, `status_i`, `eoc_i`, `zbits_i` and `stuff_req` are sampled only on the first enabled bit of a frame. Changes later in the frame have no effect on that frame.
- R6: A one-cycle pulse on `febe_i` at any time sets the far-end block error bit of the next frame that starts. The bit is cleared again for the frame after that.
- R7: The CRC6 uses generator x^6 + x + 1 and starts at zero for each frame. It covers, in transmit order, overhead indices 6..31 and all payload bits. The sync field, the CRC field and the stuffing bits are excluded.
- R8: The CRC6 of frame N is sent in the CRC field of frame N+1. The first frame after reset sends zero.
- R9: A pulse on `crc_inj` inverts all six bits of the CRC field in the next frame that starts after it. Only that one frame is affected.
- R10: `pay_ready` is high exactly when `bit_en` is high during a payload bit. When `pay_valid` is also high, `pay_data` is the bit sent. When `pay_valid` is low, a 1 is sent in that position.
- R11: Each cycle with `bit_en` high produces one output bit with `tx_valid` high on the following cycle. A cycle with `bit_en` low advances nothing and gives `tx_valid` low on the following cycle.
- R12: After reset `tx_valid`, `tx_bit`, `tx_sync` and `tx_fstart` are 0, and the next enabled bit is the first bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advance by one line bit this cycle |
| pay_valid | input | 1 | Payload bit available |
| pay_data | input | 1 | Payload bit |
| pay_ready | output | 1 | Payload bit taken this cycle |
| los_i | input | 1 | Loss-of-signal flag |
| bpv_i | input | 1 | Bipolar-violation flag |
| febe_i | input | 1 | Receive-side CRC error pulse |
| status_i | input | 10 | General indicator bits from host |
| eoc_i | input | 13 | Embedded operations channel bits from host |
| zbits_i | input | 4 | Stuffing bit content from host |
| stuff_req | input | 1 | Append stuffing to the frame |
| crc_inj | input | 1 | One-shot CRC field inversion request |
| tx_valid | output | 1 | Output bit valid |
| tx_bit | output | 1 | Output line bit |
| tx_sync | output | 1 | Output bit is in the sync field |
| tx_fstart | output | 1 | Output bit is the first of a frame |

## Verification
Some properties are checked by assertions on every cycle: one output bit per enable, sync bits at zero with the strobe, a sync run of at most 14 bits, the payload handshake and underrun fill, and the CRC accumulator clearing at each frame start. The bench's scenarios are needed for the rest. Those are the exact overhead layout, the sampling at frame start against mid-frame changes, the stuffing length and content, the sticky far-end error bit, the CRC value carried into the next frame, and the single inverted CRC field after an injection request.

// File: rtl/hoh_pkg.sv
package hoh_pkg;

  typedef enum logic [1:0] {
    F_SYNC  = 2'd0,
    F_OH    = 2'd1,
    F_PAY   = 2'd2,
    F_STUFF = 2'd3
  } field_e;

  localparam int CRC_W = 6;
  // x^6 + x + 1 without the leading term
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011;

  // one serial step of the CRC register, data bit enters at the top
  function automatic logic [CRC_W-1:0] crc6_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/hoh_seq.sv
module hoh_seq
  import hoh_pkg::*;
#(
  parameter int SYNC_W  = 14,
  parameter int GRP_W   = 8,
  parameter int BLK_W   = 16,
  parameter int NGRP    = 4,
  parameter int STUFF_W = 4,
  parameter int OH_BITS = 32,
  localparam int CW     = $clog2(max4(SYNC_W, GRP_W, BLK_W, STUFF_W) + 1),
  localparam int OIW    = $clog2(OH_BITS),
  localparam int SIW    = (STUFF_W > 1) ? $clog2(STUFF_W) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           stuff_cur,
  output field_e         field,
  output logic [OIW-1:0] oh_idx,
  output logic [SIW-1:0] stuff_idx,
  output logic           frame_start
);

  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;

  field_e          field_q;
  logic [CW-1:0]   cnt_q;
  logic [GW-1:0]   grp_q;
  logic [OIW-1:0]  oh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= F_SYNC;
      cnt_q   <= '0;
      grp_q   <= '0;
      oh_q    <= '0;
    end else if (en) begin
      unique case (field_q)
        F_SYNC: begin
          if (cnt_q == CW'(SYNC_W - 1)) begin
            field_q <= F_OH;
            cnt_q   <= '0;
            grp_q   <= '0;
            oh_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        F_OH: begin
          oh_q <= oh_q + 1'b1;
          if (cnt_q == CW'(GRP_W - 1)) begin
            field_q <= F_PAY;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        F_PAY: begin
          if (cnt_q == CW'(BLK_W - 1)) begin
            cnt_q <= '0;
            if (grp_q == GW'(NGRP - 1)) begin
              field_q <= stuff_cur ? F_STUFF : F_SYNC;
            end else begin
              field_q <= F_OH;
              grp_q   <= grp_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        F_STUFF: begin
          if (cnt_q == CW'(STUFF_W - 1)) begin
            field_q <= F_SYNC;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          field_q <= F_SYNC;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign field       = field_q;
  assign oh_idx      = oh_q;
  assign stuff_idx   = cnt_q[SIW-1:0];
  assign frame_start = en && (field_q == F_SYNC) && (cnt_q == '0);

endmodule

// File: rtl/hoh_crc6.sv
module hoh_crc6
  import hoh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  logic             din,
  input  logic             inj_i,
  output logic [CRC_W-1:0] crc_acc,
  output logic [CRC_W-1:0] crc_tx
);

  logic [CRC_W-1:0] acc_q;
  logic [CRC_W-1:0] tx_q;
  logic             armed_q;

  // on the first bit of a frame the finished remainder moves to the
  // transmit holding register and the accumulator restarts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      tx_q    <= '0;
      armed_q <= 1'b0;
    end else if (clear) begin
      tx_q    <= acc_q ^ {CRC_W{armed_q | inj_i}};
      acc_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (upd)   acc_q   <= crc6_step(acc_q, din);
      if (inj_i) armed_q <= 1'b1;
    end
  end

  assign crc_acc = acc_q;
  assign crc_tx  = tx_q;

endmodule

// File: rtl/hoh_snap.sv
module hoh_snap
  import hoh_pkg::*;
#(
  parameter int STAT_W  = 10,
  parameter int EOC_W   = 13,
  parameter int STUFF_W = 4,
  localparam int FIX_W  = EOC_W + STAT_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic               los_i,
  input  logic               bpv_i,
  input  logic               febe_i,
  input  logic [STAT_W-1:0]  status_i,
  input  logic [EOC_W-1:0]   eoc_i,
  input  logic [STUFF_W-1:0] zbits_i,
  input  logic               stuff_req,
  output logic [FIX_W-1:0]   fix_word,
  output logic [STUFF_W-1:0] zbits_q,
  output logic               stuff_q
);

  logic               febe_pend;
  logic               febe_q;
  logic               los_q;
  logic               bpv_q;
  logic [STAT_W-1:0]  stat_q;
  logic [EOC_W-1:0]   eoc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      febe_pend <= 1'b0;
      febe_q    <= 1'b0;
      los_q     <= 1'b0;
      bpv_q     <= 1'b0;
      stat_q    <= '0;
      eoc_q     <= '0;
      zbits_q   <= '0;
      stuff_q   <= 1'b0;
    end else if (cap) begin
      febe_q    <= febe_pend | febe_i;
      febe_pend <= 1'b0;
      los_q     <= los_i;
      bpv_q     <= bpv_i;
      stat_q    <= status_i;
      eoc_q     <= eoc_i;
      zbits_q   <= zbits_i;
      stuff_q   <= stuff_req;
    end else if (febe_i) begin
      febe_pend <= 1'b1;
    end
  end

  // transmit order is LSB first: febe, los, bpv, status, eoc
  assign fix_word = {eoc_q, stat_q, bpv_q, los_q, febe_q};

endmodule

// File: rtl/hoh_mux.sv
module hoh_mux
  import hoh_pkg::*;
#(
  parameter int SYNC_W   = 14,
  parameter int IND_W    = 19,
  parameter int EOC_W    = 13,
  parameter int STUFF_W  = 4,
  parameter int NGRP     = 4,
  parameter int BLK_W    = 16,
  localparam int STAT_W  = IND_W - CRC_W - 3,
  localparam int OH_BITS = IND_W + EOC_W,
  localparam int GRP_W   = OH_BITS / NGRP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               pay_valid,
  input  logic               pay_data,
  output logic               pay_ready,
  input  logic               los_i,
  input  logic               bpv_i,
  input  logic               febe_i,
  input  logic [STAT_W-1:0]  status_i,
  input  logic [EOC_W-1:0]   eoc_i,
  input  logic [STUFF_W-1:0] zbits_i,
  input  logic               stuff_req,
  input  logic               crc_inj,
  output logic               tx_valid,
  output logic               tx_bit,
  output logic               tx_sync,
  output logic               tx_fstart
);

  localparam int OIW   = $clog2(OH_BITS);
  localparam int SIW   = (STUFF_W > 1) ? $clog2(STUFF_W) : 1;
  localparam int FIX_W = OH_BITS - CRC_W;

  // named internal events, also watched by the checker
  field_e             field;
  logic [OIW-1:0]     oh_idx;
  logic [SIW-1:0]     stuff_idx;
  logic               frame_start;
  logic               prot_bit;
  logic               nxt_bit;
  logic [CRC_W-1:0]   crc_acc;
  logic [CRC_W-1:0]   crc_tx;
  logic [CRC_W-1:0]   crc_rev;
  logic [FIX_W-1:0]   fix_word;
  logic [OH_BITS-1:0] oh_word;
  logic [STUFF_W-1:0] zbits_q;
  logic               stuff_q;

  hoh_seq #(
    .SYNC_W (SYNC_W),
    .GRP_W  (GRP_W),
    .BLK_W  (BLK_W),
    .NGRP   (NGRP),
    .STUFF_W(STUFF_W),
    .OH_BITS(OH_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (bit_en),
    .stuff_cur  (stuff_q),
    .field      (field),
    .oh_idx     (oh_idx),
    .stuff_idx  (stuff_idx),
    .frame_start(frame_start)
  );

  hoh_snap #(
    .STAT_W (STAT_W),
    .EOC_W  (EOC_W),
    .STUFF_W(STUFF_W)
  ) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (frame_start),
    .los_i    (los_i),
    .bpv_i    (bpv_i),
    .febe_i   (febe_i),
    .status_i (status_i),
    .eoc_i    (eoc_i),
    .zbits_i  (zbits_i),
    .stuff_req(stuff_req),
    .fix_word (fix_word),
    .zbits_q  (zbits_q),
    .stuff_q  (stuff_q)
  );

  hoh_crc6 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (frame_start),
    .upd    (prot_bit),
    .din    (nxt_bit),
    .inj_i  (crc_inj),
    .crc_acc(crc_acc),
    .crc_tx (crc_tx)
  );

  // CRC field goes out MSB first, so index 0 holds the top bit
  for (genvar i = 0; i < CRC_W; i++) begin : g_crc_rev
    assign crc_rev[i] = crc_tx[CRC_W-1-i];
  end

  assign oh_word   = {fix_word, crc_rev};
  assign pay_ready = bit_en && (field == F_PAY);

  always_comb begin
    unique case (field)
      F_SYNC:  nxt_bit = 1'b0;
      F_OH:    nxt_bit = oh_word[oh_idx];
      F_PAY:   nxt_bit = pay_valid ? pay_data : 1'b1;
      F_STUFF: nxt_bit = zbits_q[stuff_idx];
      default: nxt_bit = 1'b0;
    endcase
  end

  assign prot_bit = bit_en &&
                    (((field == F_OH) && (oh_idx >= OIW'(CRC_W))) || (field == F_PAY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid  <= 1'b0;
      tx_bit    <= 1'b0;
      tx_sync   <= 1'b0;
      tx_fstart <= 1'b0;
    end else begin
      tx_valid <= bit_en;
      if (bit_en) begin
        tx_bit    <= nxt_bit;
        tx_sync   <= (field == F_SYNC);
        tx_fstart <= frame_start;
      end else begin
        tx_sync   <= 1'b0;
        tx_fstart <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hoh_mux_chk.sv
module hoh_mux_chk
  import hoh_pkg::*;
#(
  parameter int SYNC_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             pay_valid,
  input logic             pay_data,
  input logic             pay_ready,
  input logic             tx_valid,
  input logic             tx_bit,
  input logic             tx_sync,
  input logic             tx_fstart,
  input logic             frame_start,
  input logic [CRC_W-1:0] crc_acc
);

  int unsigned sync_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sync_run <= 0;
    else if (tx_valid) sync_run <= tx_sync ? sync_run + 1 : 0;
  end

  // R1
  p_sync_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sync) |-> (sync_run < SYNC_W));

  // R1
  p_fstart_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fstart |-> (tx_sync && sync_run == 0));

  // R2
  p_sync_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sync |-> (tx_valid && !tx_bit));

  // R7
  p_crc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (crc_acc == '0));

  // R10
  p_ready_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> bit_en);

  // R10
  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && pay_valid) |=> (tx_valid && tx_bit == $past(pay_data)));

  // R10
  p_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && !pay_valid) |=> (tx_valid && tx_bit));

  // R11
  p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> tx_valid);

  // R11
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> (!tx_valid && !tx_sync));

endmodule

bind hoh_mux hoh_mux_chk #(.SYNC_W(SYNC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .pay_valid  (pay_valid),
  .pay_data   (pay_data),
  .pay_ready  (pay_ready),
  .tx_valid   (tx_valid),
  .tx_bit     (tx_bit),
  .tx_sync    (tx_sync),
  .tx_fstart  (tx_fstart),
  .frame_start(frame_start),
  .crc_acc    (crc_acc)
);

// File: tb/sim_hoh_mux.sv
module sim_hoh_mux;

  localparam int SYNC_W = 14;
  localparam int NGRP   = 4;
  localparam int GRP_W  = 8;
  localparam int BLK_W  = 16;
  localparam int BODY   = NGRP * (GRP_W + BLK_W);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, pay_valid = 1'b0, pay_data = 1'b0;
  logic        los_i = 1'b0, bpv_i = 1'b0, febe_i = 1'b0;
  logic [9:0]  status_i = '0;
  logic [12:0] eoc_i = '0;
  logic [3:0]  zbits_i = '0;
  logic        stuff_req = 1'b0, crc_inj = 1'b0;
  logic        pay_ready, tx_valid, tx_bit, tx_sync, tx_fstart;

  hoh_mux u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pay_valid(pay_valid),
    .pay_data(pay_data), .pay_ready(pay_ready), .los_i(los_i), .bpv_i(bpv_i),
    .febe_i(febe_i), .status_i(status_i), .eoc_i(eoc_i), .zbits_i(zbits_i),
    .stuff_req(stuff_req), .crc_inj(crc_inj), .tx_valid(tx_valid),
    .tx_bit(tx_bit), .tx_sync(tx_sync), .tx_fstart(tx_fstart)
  );

  typedef struct {
    logic  b;
    logic  s;
    logic  f;
    string tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, errors = 0;
  logic [5:0]  crc_prev = '0;
  bit          inj_pend = 1'b0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // long division of message * x^6 by x^6 + x + 1
  function automatic logic [5:0] ref_crc(input bit bits[$]);
    logic [6:0] r;
    bit         b;
    r = '0;
    for (int i = 0; i < bits.size() + 6; i++) begin
      b = (i < bits.size()) ? bits[i] : 1'b0;
      r = {r[5:0], b};
      if (r[6]) r = r ^ 7'b1000011;
    end
    return r[5:0];
  endfunction

  task automatic idle(input bit pf, input bit pi);
    bit_en    = 1'b0;
    pay_valid = 1'b0;
    febe_i    = pf;
    crc_inj   = pi;
    #1 chk(pay_ready == 1'b0, "R11 ready while idle", pay_ready, 0);
    @(negedge clk);
    febe_i  = 1'b0;
    crc_inj = 1'b0;
  endtask

  task automatic run_frame(input bit stuff, input bit los, input bit bpv,
                           input logic [9:0] st, input logic [12:0] eoc,
                           input logic [3:0] z, input bit exp_febe,
                           input int gap, input int under,
                           input bit pf, input bit pi, input int seed);
    bit         oh[32];
    bit         prot[$];
    logic [5:0] crc_s;
    int         len;
    bit         eb, val, dat, is_pay, is_sync;
    string      tag;
    crc_s    = crc_prev ^ {6{inj_pend}};
    inj_pend = 1'b0;
    for (int i = 0; i < 6; i++)  oh[i] = crc_s[5-i];
    oh[6] = exp_febe;
    oh[7] = los;
    oh[8] = bpv;
    for (int i = 0; i < 10; i++) oh[9+i]  = st[i];
    for (int i = 0; i < 13; i++) oh[19+i] = eoc[i];
    los_i = los; bpv_i = bpv; status_i = st; eoc_i = eoc;
    zbits_i = z; stuff_req = stuff;
    len = SYNC_W + BODY + (stuff ? 4 : 0);
    for (int p = 0; p < len; p++) begin
      if (p == 50) idle(pf, pi);
      else if (gap > 0 && p > 0 && (p % gap) == 0) idle(1'b0, 1'b0);
      is_pay  = 1'b0;
      is_sync = 1'b0;
      val = 1'b0; dat = 1'b0;
      if (p < SYNC_W) begin
        is_sync = 1'b1; eb = 1'b0; tag = "R2 sync bit";
      end else if (p - SYNC_W < BODY) begin
        int q, r, k;
        q = p - SYNC_W;
        r = q % (GRP_W + BLK_W);
        if (r < GRP_W) begin
          k  = (q / (GRP_W + BLK_W)) * GRP_W + r;
          eb = oh[k];
          if (k >= 6) prot.push_back(eb);
          if (k < 6)       tag = pi ? "R4 crc bit" : (inj_pend ? "R4" : "R7/R8 crc bit");
          else if (k == 6) tag = "R6 febe bit";
          else if (k < 9)  tag = "R5 los/bpv bit";
          else             tag = "R4 overhead bit";
          if (k < 6 && crc_s != crc_prev) tag = "R9 inverted crc bit";
        end else begin
          is_pay = 1'b1;
          val = !(under > 0 && (p % under) == 0);
          dat = ((p * 13 + seed) >> 2) & 1;
          eb  = val ? dat : 1'b1;
          prot.push_back(eb);
          tag = "R10 payload bit";
        end
      end else begin
        eb  = z[p - SYNC_W - BODY];
        tag = "R3 stuffing bit";
      end
      bit_en    = 1'b1;
      pay_valid = val;
      pay_data  = dat;
      sb.push_back('{eb, is_sync, (p == 0), tag});
      #1 chk(pay_ready == is_pay, "R10 pay_ready", pay_ready, is_pay);
      @(negedge clk);
      if (p == 0) begin
        // R5: later changes must not reach this frame
        los_i = ~los; bpv_i = ~bpv; status_i = ~st; eoc_i = ~eoc;
        zbits_i = ~z; stuff_req = ~stuff;
      end
    end
    bit_en    = 1'b0;
    pay_valid = 1'b0;
    crc_prev  = ref_crc(prot);
    if (pi) inj_pend = 1'b1;
  endtask

  // monitor: pops expected bits as the design emits them
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && tx_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11 unexpected output bit", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(tx_bit == e.b, e.tag, tx_bit, e.b);
          chk(tx_sync == e.s, "R2 sync strobe", tx_sync, e.s);
          chk(tx_fstart == e.f, "R1 frame start", tx_fstart, e.f);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R12 tx_valid in reset", tx_valid, 0);
    chk(tx_bit == 1'b0, "R12 tx_bit in reset", tx_bit, 0);
    chk(tx_sync == 1'b0, "R12 tx_sync in reset", tx_sync, 0);
    chk(tx_fstart == 1'b0, "R12 tx_fstart in reset", tx_fstart, 0);
    chk(pay_ready == 1'b0, "R12 pay_ready in reset", pay_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // plain frame, first CRC field is zero
    run_frame(1'b0, 1'b1, 1'b0, 10'h2A5, 13'h1ABC, 4'h0, 1'b0, 0, 0, 1'b0, 1'b0, 3);
    // stuffed frame with gaps, underruns and a febe pulse
    run_frame(1'b1, 1'b0, 1'b1, 10'h15A, 13'h0543, 4'b1010, 1'b0, 7, 11, 1'b1, 1'b0, 5);
    idle(1'b0, 1'b0);
    // febe shows here; injection request during this frame
    run_frame(1'b0, 1'b1, 1'b1, 10'h3C3, 13'h1F0F, 4'h5, 1'b1, 5, 0, 1'b0, 1'b1, 9);
    // inverted CRC field expected here
    run_frame(1'b1, 1'b0, 1'b0, 10'h0F1, 13'h0AAA, 4'b0110, 1'b0, 0, 9, 1'b0, 1'b0, 1);
    // back to a normal CRC field
    run_frame(1'b0, 1'b1, 1'b0, 10'h200, 13'h1001, 4'h3, 1'b0, 4, 6, 1'b0, 1'b0, 7);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R11 all bits emitted", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule